// File: doc/BRIEF.md
# TDM Receive Time-Slot Extractor

This block watches one serial time-division-multiplexed receive line and turns the bits of selected time slots into payload octets. The line's bit clock, frame pulse and data are oversampled by the block's own system clock. A programmable sampling edge picks the bit instants. The frame pulse marks the first bit of each frame. A 32-bit slot-enable bitmap, owned by the receive direction alone, chooses which slots carry payload. Every other bit is thrown away.

Two frame formats are supported. In the 32-slot format a frame is 256 bits, with slot 0 starting at the frame pulse. In the 24-slot format a frame is 193 bits. Its leading framing bit is dropped, and only bitmap bits 0 to 23 take part. Each finished octet leaves on a byte bus with a one-cycle strobe and the number of the slot it came from. Changes to the bitmap, the format, the pulse polarity or the sampling edge take effect at a frame boundary. A stray frame pulse restarts the frame and is flagged.

Top module: `tdm_rx_slot_extractor`

## Requirements
- R1: After reset `oct_valid`, `frame_aligned` and `frame_slip` are 0, and no octet is produced until the first active frame pulse has been sampled.
- R2: The first sampled active frame pulse sets `frame_aligned`, which then stays 1 until reset. The bit carrying that pulse is bit 0 of a frame.
- R3: Slot bits are assembled MSB first: the first bit of a slot becomes `oct_data[7]`. The octet appears for exactly one system cycle with `oct_slot` holding the slot number. It appears 2 system cycles after the system-clock edge at which the sampling edge of the slot's last bit was first presented on `line_clk`.
- R4: Bitmap bit n enables slot n. A slot whose bit is 0 produces no octet.
- R5: With `cfg_t1_mode` = 0 a frame is 256 bits, and frame bit p belongs to slot p/8.
- R6: With `cfg_t1_mode` = 1 a frame is 193 bits. Bit 0 is discarded, and bit p (1..192) belongs to slot (p-1)/8. Bitmap bits 24 to 31 are ignored and no slot number above 23 is produced.
- R7: Once aligned, a frame without a frame pulse is still counted and extracted at the expected positions.
- R8: An active frame pulse at any position other than the expected frame start does four things. It makes that bit bit 0 of a new frame and discards the partial octet. It pulses `frame_slip` for one cycle. It leaves `frame_aligned` at 1.
- R9: Changes to the bitmap and format made while aligned take effect from bit 0 of the next frame. The current frame keeps the old settings.
- R10: `cfg_fp_active_low` = 1 treats a low `line_fp` as the frame pulse, and 0 treats a high one as the pulse.
- R11: `cfg_sample_falling` = 1 samples data and frame pulse on falling edges of `line_clk`, and 0 samples them on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the line |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Line bit clock |
| line_fp | input | 1 | Line frame pulse |
| line_data | input | 1 | Line serial data |
| cfg_map | input | 32 | Slot-enable bitmap, bit n for slot n |
| cfg_t1_mode | input | 1 | 1: 193-bit 24-slot frame, 0: 256-bit 32-slot frame |
| cfg_fp_active_low | input | 1 | Frame pulse polarity, 1 = active low |
| cfg_sample_falling | input | 1 | Sampling edge, 1 = falling |
| oct_valid | output | 1 | One-cycle strobe for a completed octet |
| oct_data | output | 8 | Completed octet, first received bit in bit 7 |
| oct_slot | output | 5 | Slot number of the octet |
| frame_aligned | output | 1 | Frame alignment achieved |
| frame_slip | output | 1 | One-cycle pulse on an unexpected frame pulse |

## Verification
A wrong frame position or wrong slot decode shows at the ports at once. The bytes come out shifted in value, carry the wrong slot tag, or appear for slots that are switched off. Each of these is caught at the first octet strobe after the fault, at most eight line bits later. A shadow configuration loaded at the wrong time changes which slots emit octets in the frame where the bitmap was written, so it shows within one frame. An alignment fault shows as early or missing octets, or as a slip pulse in a clean frame, on the cycle it happens.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int NUM_SLOTS = 32;
    localparam int T1_SLOTS  = 24;
    localparam int OCT_W     = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int BIT_W     = $clog2(OCT_W);
    localparam int POS_W     = $clog2(NUM_SLOTS * OCT_W);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] map;
        logic                 t1;
        logic                 fp_low;
        logic                 fall;
    } rx_cfg_t;

    typedef struct packed {
        logic ev;
        logic d;
        logic fp;
    } line_smp_t;

    typedef struct packed {
        logic              fr_bit;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bidx;
    } slot_pos_t;

    typedef struct packed {
        logic              valid;
        logic              take;
        logic              d;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bidx;
        logic              restart;
    } rx_bit_t;

    function automatic logic [POS_W-1:0] frame_last(input logic t1);
        return t1 ? POS_W'(T1_SLOTS * OCT_W) : POS_W'(NUM_SLOTS * OCT_W - 1);
    endfunction

    function automatic slot_pos_t decode_pos(input logic [POS_W-1:0] pos, input logic t1);
        slot_pos_t        r;
        logic [POS_W-1:0] p;
        p        = t1 ? (pos - POS_W'(1)) : pos;
        r.fr_bit = t1 && (pos == '0);
        r.slot   = p[POS_W-1:BIT_W];
        r.bidx   = p[BIT_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge
    import tdm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_clk,
    input  logic      line_fp,
    input  logic      line_data,
    input  logic      use_fall,
    input  logic      fp_low,
    output line_smp_t smp
);

    logic [SYNC_STAGES-1:0] clk_sr;
    logic [SYNC_STAGES-1:0] fp_sr;
    logic [SYNC_STAGES-1:0] dat_sr;
    logic                   clk_prev;
    logic                   clk_now;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    clk_sr <= '0;
                    fp_sr  <= '0;
                    dat_sr <= '0;
                end else begin
                    clk_sr <= line_clk;
                    fp_sr  <= line_fp;
                    dat_sr <= line_data;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    clk_sr <= '0;
                    fp_sr  <= '0;
                    dat_sr <= '0;
                end else begin
                    clk_sr <= {clk_sr[SYNC_STAGES-2:0], line_clk};
                    fp_sr  <= {fp_sr[SYNC_STAGES-2:0], line_fp};
                    dat_sr <= {dat_sr[SYNC_STAGES-2:0], line_data};
                end
            end
        end
    endgenerate

    assign clk_now = clk_sr[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b0;
        else     clk_prev <= clk_now;
    end

    always_comb begin
        smp.ev = use_fall ? (clk_prev && !clk_now) : (clk_now && !clk_prev);
        smp.d  = dat_sr[SYNC_STAGES-1];
        smp.fp = fp_sr[SYNC_STAGES-1] ^ fp_low;
    end

    AST_EVENT_SPACED: assert property (@(posedge clk) disable iff (rst)
        smp.ev |=> !smp.ev) else $error("sample events back to back"); // R11

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_smp_t smp,
    input  rx_cfg_t   cfg_i,
    output rx_cfg_t   act_cfg,
    output rx_bit_t   bev,
    output logic      aligned,
    output logic      slip
);

    rx_cfg_t          act_q;
    rx_cfg_t          eff;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;
    logic             aligned_q;
    logic             slip_q;
    logic             at_end;
    logic             fp_hit;
    logic             boundary;
    logic             slip_now;
    logic             now_aligned;
    slot_pos_t        dec;

    always_comb begin
        at_end      = (pos_q == frame_last(act_q.t1));
        fp_hit      = smp.ev && smp.fp;
        boundary    = fp_hit || (smp.ev && aligned_q && at_end);
        slip_now    = fp_hit && aligned_q && !at_end;
        now_aligned = aligned_q || fp_hit;
        if (fp_hit || at_end) pos_d = '0;
        else                  pos_d = pos_q + POS_W'(1);
        eff         = boundary ? cfg_i : act_q;
        dec         = decode_pos(pos_d, eff.t1);
        bev.valid   = smp.ev && now_aligned;
        bev.take    = !dec.fr_bit && eff.map[dec.slot];
        bev.d       = smp.d;
        bev.slot    = dec.slot;
        bev.bidx    = dec.bidx;
        bev.restart = slip_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            aligned_q <= 1'b0;
            slip_q    <= 1'b0;
            act_q     <= cfg_i;
        end else begin
            slip_q <= slip_now;
            if (smp.ev && now_aligned) pos_q <= pos_d;
            aligned_q <= now_aligned;
            if (!aligned_q || boundary) act_q <= cfg_i;
        end
    end

    assign act_cfg = act_q;
    assign aligned = aligned_q;
    assign slip    = slip_q;

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        pos_q <= frame_last(act_q.t1)) else $error("frame position past end"); // R5
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        aligned_q |=> aligned_q) else $error("alignment lost"); // R2
    AST_SLIP_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        slip_q |-> aligned_q) else $error("slip without alignment"); // R8
    AST_SLIP_PULSE: assert property (@(posedge clk) disable iff (rst)
        slip_q |=> !slip_q) else $error("slip flag longer than a cycle"); // R8

endmodule

// File: rtl/tdm_rx_packer.sv
module tdm_rx_packer
    import tdm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_bit_t           bev,
    output logic              oct_valid,
    output logic [OCT_W-1:0]  oct_data,
    output logic [SLOT_W-1:0] oct_slot
);

    logic [OCT_W-1:0] sh_q;
    logic [OCT_W-1:0] sh_next;
    logic             shift_en;
    logic             done;

    always_comb begin
        shift_en = bev.valid && bev.take;
        sh_next  = {sh_q[OCT_W-2:0], bev.d};
        done     = shift_en && (bev.bidx == BIT_W'(OCT_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            oct_valid <= 1'b0;
            oct_data  <= '0;
            oct_slot  <= '0;
        end else begin
            oct_valid <= done;
            if (bev.restart && !shift_en) sh_q <= '0;
            else if (shift_en)            sh_q <= sh_next;
            if (done) begin
                oct_data <= sh_next;
                oct_slot <= bev.slot;
            end
        end
    end

    AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
        oct_valid |=> !oct_valid) else $error("octet strobe too long"); // R3

endmodule

// File: rtl/tdm_rx_slot_extractor.sv
module tdm_rx_slot_extractor
    import tdm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_clk,
    input  logic                 line_fp,
    input  logic                 line_data,
    input  logic [NUM_SLOTS-1:0] cfg_map,
    input  logic                 cfg_t1_mode,
    input  logic                 cfg_fp_active_low,
    input  logic                 cfg_sample_falling,
    output logic                 oct_valid,
    output logic [OCT_W-1:0]     oct_data,
    output logic [SLOT_W-1:0]    oct_slot,
    output logic                 frame_aligned,
    output logic                 frame_slip
);

    rx_cfg_t   cfg_in;
    rx_cfg_t   act_cfg;
    line_smp_t smp;
    rx_bit_t   bev;

    always_comb begin
        cfg_in.map    = cfg_map;
        cfg_in.t1     = cfg_t1_mode;
        cfg_in.fp_low = cfg_fp_active_low;
        cfg_in.fall   = cfg_sample_falling;
    end

    tdm_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk      (clk),
        .rst      (rst),
        .line_clk (line_clk),
        .line_fp  (line_fp),
        .line_data(line_data),
        .use_fall (act_cfg.fall),
        .fp_low   (act_cfg.fp_low),
        .smp      (smp)
    );

    tdm_rx_framer i_framer (
        .clk    (clk),
        .rst    (rst),
        .smp    (smp),
        .cfg_i  (cfg_in),
        .act_cfg(act_cfg),
        .bev    (bev),
        .aligned(frame_aligned),
        .slip   (frame_slip)
    );

    tdm_rx_packer i_packer (
        .clk      (clk),
        .rst      (rst),
        .bev      (bev),
        .oct_valid(oct_valid),
        .oct_data (oct_data),
        .oct_slot (oct_slot)
    );

    AST_QUIET_UNTIL_LOCK: assert property (@(posedge clk) disable iff (rst)
        oct_valid |-> frame_aligned) else $error("octet before alignment"); // R1
    AST_T1_SLOT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (oct_valid && act_cfg.t1) |-> (oct_slot < SLOT_W'(T1_SLOTS))) else $error("slot above 23 in 24-slot format"); // R6

endmodule

// File: tb/test_tdm_rx_slot_extractor.sv
`timescale 1ns/1ps
module test_tdm_rx_slot_extractor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_clk = 1'b0;
    logic        line_fp = 1'b0;
    logic        line_data = 1'b0;
    logic [31:0] cfg_map = '0;
    logic        cfg_t1_mode = 1'b0;
    logic        cfg_fp_active_low = 1'b0;
    logic        cfg_sample_falling = 1'b0;
    logic        oct_valid;
    logic [7:0]  oct_data;
    logic [4:0]  oct_slot;
    logic        frame_aligned;
    logic        frame_slip;

    always #2.5 clk = ~clk;

    tdm_rx_slot_extractor i_tdm_rx_slot_extractor (
        .clk(clk), .rst(rst), .line_clk(line_clk), .line_fp(line_fp), .line_data(line_data),
        .cfg_map(cfg_map), .cfg_t1_mode(cfg_t1_mode), .cfg_fp_active_low(cfg_fp_active_low),
        .cfg_sample_falling(cfg_sample_falling), .oct_valid(oct_valid), .oct_data(oct_data),
        .oct_slot(oct_slot), .frame_aligned(frame_aligned), .frame_slip(frame_slip)
    );

    typedef struct { int due; logic [7:0] d; logic [4:0] s; } exp_t;
    exp_t exp_q[$];
    int   slip_q[$];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int octs = 0;
    bit running = 0;

    bit          m_al;
    int          m_al_due;
    int          m_pos;
    logic [31:0] m_map;
    bit          m_t1;
    logic [7:0]  m_sh;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            bit ev, em, ea;
            ev = (exp_q.size() > 0) && (exp_q[0].due == cyc);
            em = (slip_q.size() > 0) && (slip_q[0] == cyc);
            ea = m_al && (cyc >= m_al_due);
            if (oct_valid !== ev)
                check(0, ev ? "R3" : "R4", "octet strobe", int'(oct_valid), int'(ev));
            else if (ev) begin
                check(oct_data === exp_q[0].d, "R3", "octet data", int'(oct_data), int'(exp_q[0].d));
                check(oct_slot === exp_q[0].s, "R3", "octet slot", int'(oct_slot), int'(exp_q[0].s));
                octs++;
            end
            if (ev) void'(exp_q.pop_front());
            if (frame_aligned !== ea) check(0, "R2", "aligned flag", int'(frame_aligned), int'(ea));
            if (frame_slip !== em) check(0, "R8", "slip flag", int'(frame_slip), int'(em));
            if (em) void'(slip_q.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic model_bit(input logic d, input bit fp);
        int last, p, slot, bi;
        last = m_t1 ? 192 : 255;
        if (fp) begin
            if (m_al && m_pos != last) slip_q.push_back(cyc + 2);
            if (!m_al) m_al_due = cyc + 2;
            m_al = 1; m_pos = 0; m_map = cfg_map; m_t1 = cfg_t1_mode;
        end else if (m_al) begin
            if (m_pos == last) begin
                m_pos = 0; m_map = cfg_map; m_t1 = cfg_t1_mode;
            end else m_pos++;
        end
        if (m_al && !(m_t1 && m_pos == 0)) begin
            p = m_t1 ? m_pos - 1 : m_pos;
            slot = p / 8; bi = p % 8;
            if (m_map[slot]) begin
                m_sh = {m_sh[6:0], d};
                if (bi == 7) begin
                    exp_t e;
                    e.due = cyc + 2; e.d = m_sh; e.s = 5'(slot);
                    exp_q.push_back(e);
                end
            end
        end
    endtask

    task automatic send_bit(input logic d, input bit fp);
        @(negedge clk);
        line_clk  = cfg_sample_falling;
        line_data = d;
        line_fp   = fp ^ cfg_fp_active_low;
        @(negedge clk);
        @(negedge clk);
        line_clk = ~cfg_sample_falling;
        model_bit(d, fp);
        @(negedge clk);
    endtask

    task automatic send_run(input int n, input bit fp_first);
        for (int i = 0; i < n; i++) send_bit(1'($urandom), fp_first && i == 0);
    endtask

    task automatic do_reset(input logic [31:0] map, input bit t1, input bit fpl, input bit fall);
        @(negedge clk);
        running = 0; rst = 1;
        cfg_map = map; cfg_t1_mode = t1; cfg_fp_active_low = fpl; cfg_sample_falling = fall;
        line_clk = fall; line_fp = fpl; line_data = 0;
        repeat (3) @(negedge clk);
        exp_q.delete(); slip_q.delete();
        m_al = 0; m_al_due = 0; m_pos = 0; m_map = map; m_t1 = t1; m_sh = 0;
        rst = 0; running = 1;
        @(negedge clk);
        check(oct_valid === 0, "R1", "valid after reset", int'(oct_valid), 0);
        check(frame_aligned === 0, "R1", "aligned after reset", int'(frame_aligned), 0);
        check(frame_slip === 0, "R1", "slip after reset", int'(frame_slip), 0);
    endtask

    task automatic drain(input string req);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, req, "octets left undelivered", exp_q.size(), 0);
        check(slip_q.size() == 0, "R8", "slip pulses left undelivered", slip_q.size(), 0);
    endtask

    initial begin
        int base;
        // 32-slot format, rising edge, active-high pulse
        do_reset(32'hA5C3_0F81, 0, 0, 0);
        send_run(40, 0);
        drain("R1");
        check(octs == 0, "R1", "octets before first pulse", octs, 0);
        check(frame_aligned === 0, "R1", "aligned before first pulse", int'(frame_aligned), 0);
        base = octs;
        send_run(256, 1);
        send_run(256, 1);
        drain("R5");
        check(octs - base == 2 * $countones(32'hA5C3_0F81), "R4", "octet count for bitmap",
              octs - base, 2 * $countones(32'hA5C3_0F81));
        check(frame_aligned === 1, "R2", "aligned after pulses", int'(frame_aligned), 1);
        base = octs;
        send_run(256, 0); // R7: frame with no pulse
        drain("R7");
        check(octs - base == $countones(32'hA5C3_0F81), "R7", "octets in pulseless frame",
              octs - base, $countones(32'hA5C3_0F81));
        base = octs;
        send_run(100, 1);
        cfg_map = 32'h0000_FFFF; // R9: takes effect next frame
        send_run(156, 0);
        send_run(256, 1);
        drain("R9");
        check(octs - base == $countones(32'hA5C3_0F81) + 16, "R9", "octets across bitmap change",
              octs - base, $countones(32'hA5C3_0F81) + 16);
        send_run(100, 1);
        send_run(256, 1); // R8: pulse at bit 100
        send_run(256, 1);
        drain("R8");
        check(frame_aligned === 1, "R8", "aligned kept after slip", int'(frame_aligned), 1);

        // 24-slot format with high bitmap bits set
        do_reset(32'hFF80_0E13, 1, 0, 0);
        base = octs;
        send_run(193, 1);
        send_run(193, 1);
        send_run(193, 1);
        drain("R6");
        check(octs - base == 3 * $countones(24'h800E13), "R6", "24-slot octet count",
              octs - base, 3 * $countones(24'h800E13));

        // falling edge, active-low pulse, all slots
        do_reset(32'hFFFF_FFFF, 0, 1, 1);
        base = octs;
        send_run(256, 1);
        send_run(256, 1);
        drain("R11");
        check(octs - base == 64, "R10", "octets with low pulse and falling edge", octs - base, 64);
        check(frame_aligned === 1, "R10", "aligned on active-low pulse", int'(frame_aligned), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule